// File: doc/BRIEF.md
# Z80 Undocumented Flag Unit

This unit produces the two officially unused flag bits (bit 5, here called YF, and bit 3, here called XF) of a Z80-compatible core. It also produces two variant-dependent quirks: the carry left by the block-output instruction OUTI, and the data byte driven by the undocumented ED 71h port write. The decoder presents an instruction-class code each cycle, together with the accumulator, the incoming flag byte, the 8-bit ALU result, the 16-bit MEMPTR value and the B register as it was before the instruction. The unit answers combinationally in the same cycle.

One register remembers whether the last completed instruction wrote the flags. SCF and CCF use it to choose between copying accumulator bits and merging them with the old flag bits. The register advances only on cycles where `step_en` marks an instruction as completing.

Three parameters select the variant:
- `IS_CMOS` picks the CMOS or NMOS port byte.
- `CLONE_KEEP_CF` picks the clone carry rule for OUTI.
- `DIFF_OR` picks how SCF/CCF merge bits that disagree.

Top module: `z80_xyflag_unit`

## Requirements
- R1: For class ALU (code 0), `yf_out` equals `alu_res[5]` and `xf_out` equals `alu_res[3]`.
- R2: For class SCF (code 1) or CCF (code 2), when the history bit is 1, `yf_out` equals `acc[5]` and `xf_out` equals `acc[3]`.
- R3: For SCF or CCF when the history bit is 0 and the old flag bit equals the accumulator bit, the output bit is the AND of the two, which is their common value.
- R4: For SCF or CCF when the history bit is 0 and the old flag bit differs from the accumulator bit, the output bit is their OR when `DIFF_OR` is 1 and their AND (that is, 0) when `DIFF_OR` is 0.
- R5: For class BIT (HL) (code 3), `yf_out` equals `memptr[13]` and `xf_out` equals `memptr[11]`.
- R6: For class OUTI (code 4) with `b_pre` equal to 1, `cf_out` is 0 when `CLONE_KEEP_CF` is 0 and equals `flags_in[0]` when `CLONE_KEEP_CF` is 1.
- R7: For OUTI with any other `b_pre`, and for every class other than OUTI, `cf_out` equals `flags_in[0]`. For classes other than ALU, SCF, CCF and BIT (HL), `yf_out` and `xf_out` equal `flags_in[5]` and `flags_in[3]`.
- R8: For class OUT-zero (code 5), `port_byte` is 00h when `IS_CMOS` is 0 and FFh when `IS_CMOS` is 1. For any other class it is 00h.
- R9: The history bit is 0 after reset. On a rising edge with `step_en` high it becomes 1 after classes 0 to 4 and 0 after any other code. On an edge with `step_en` low it holds its value.
- R10: Codes 6 (POP AF), 7 (no flag change) and 8 to 15 pass the flag bits through unchanged and clear the history bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | High when the presented instruction completes this cycle |
| op_class | input | 4 | Instruction-class code |
| acc | input | 8 | Accumulator |
| flags_in | input | 8 | Current flag byte |
| alu_res | input | 8 | 8-bit ALU result |
| memptr | input | 16 | Internal MEMPTR value |
| b_pre | input | 8 | B register before the instruction |
| yf_out | output | 1 | New flag bit 5 |
| xf_out | output | 1 | New flag bit 3 |
| cf_out | output | 1 | New carry |
| port_byte | output | 8 | Data byte for the undocumented port write |

## Verification
`yf_out`, `xf_out`, `cf_out` and `port_byte` are combinational, so they are due in the same cycle as the class code that causes them. The history bit becomes visible only one rising edge after the instruction that sets or clears it, and only through the SCF/CCF result of the following instruction. The bench therefore drives every instruction on a falling edge, checks the outputs one time unit later, and lets the next rising edge commit the history before it presents the next instruction. Two instances with opposite variant parameters share one stimulus, so both detection sequences are compared against both expected results.

// File: rtl/z80xf_pkg.sv
package z80xf_pkg;
  localparam int CLS_W  = 4;
  localparam int DATA_W = 8;
  localparam int MP_W   = 16;
  localparam int YPOS   = 5;
  localparam int XPOS   = 3;
  localparam int CPOS   = 0;
  localparam int MP_YP  = 13;
  localparam int MP_XP  = 11;

  typedef enum logic [CLS_W-1:0] {
    CLS_ALU   = 4'h0,
    CLS_SCF   = 4'h1,
    CLS_CCF   = 4'h2,
    CLS_BITM  = 4'h3,
    CLS_OUTI  = 4'h4,
    CLS_OUTZ  = 4'h5,
    CLS_POPAF = 4'h6,
    CLS_NOFL  = 4'h7
  } op_cls_e;

  function automatic logic cls_writes_flags(input logic [CLS_W-1:0] c);
    case (c)
      CLS_ALU, CLS_SCF, CLS_CCF, CLS_BITM, CLS_OUTI: return 1'b1;
      default:                                       return 1'b0;
    endcase
  endfunction

  function automatic logic cls_is_carry_op(input logic [CLS_W-1:0] c);
    return (c == CLS_SCF) || (c == CLS_CCF);
  endfunction
endpackage

// File: rtl/z80xf_history.sv
module z80xf_history
  import z80xf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic [CLS_W-1:0] op_class,
  output logic             hist_q
);
  logic hist_d;

  always_comb begin
    hist_d = hist_q;
    if (step_en) hist_d = cls_writes_flags(op_class);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= 1'b0;
    else        hist_q <= hist_d;
  end

  // R9: flag-writing classes set the record
  a_r9_set: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && op_class <= CLS_OUTI) |=> hist_q);
  // R9, R10: other codes clear it
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && op_class > CLS_OUTI) |=> !hist_q);
  // R9: no completion, no change
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(hist_q));
endmodule

// File: rtl/z80xf_lane.sv
module z80xf_lane
  import z80xf_pkg::*;
#(
  parameter bit DIFF_OR = 1'b1
) (
  input  logic [CLS_W-1:0] op_class,
  input  logic             hist_q,
  input  logic             acc_bit,
  input  logic             flag_bit,
  input  logic             res_bit,
  input  logic             mp_bit,
  output logic             out_bit
);
  logic merged;

  always_comb begin
    if (flag_bit == acc_bit) merged = flag_bit & acc_bit;
    else if (DIFF_OR)        merged = flag_bit | acc_bit;
    else                     merged = flag_bit & acc_bit;
  end

  always_comb begin
    if (op_class == CLS_ALU)             out_bit = res_bit;
    else if (cls_is_carry_op(op_class))  out_bit = hist_q ? acc_bit : merged;
    else if (op_class == CLS_BITM)       out_bit = mp_bit;
    else                                 out_bit = flag_bit;
  end
endmodule

// File: rtl/z80xf_quirks.sv
module z80xf_quirks
  import z80xf_pkg::*;
#(
  parameter bit IS_CMOS       = 1'b0,
  parameter bit CLONE_KEEP_CF = 1'b0
) (
  input  logic [CLS_W-1:0]  op_class,
  input  logic [DATA_W-1:0] b_pre,
  input  logic              cf_in,
  output logic              cf_out,
  output logic [DATA_W-1:0] port_byte
);
  localparam logic [DATA_W-1:0] ZERO_OUT = IS_CMOS ? {DATA_W{1'b1}} : '0;
  localparam logic [DATA_W-1:0] B_LAST   = DATA_W'(1);

  logic last_pass;
  assign last_pass = (op_class == CLS_OUTI) && (b_pre == B_LAST);

  always_comb begin
    cf_out = cf_in;
    if (last_pass && !CLONE_KEEP_CF) cf_out = 1'b0;
  end

  always_comb begin
    port_byte = '0;
    if (op_class == CLS_OUTZ) port_byte = ZERO_OUT;
  end
endmodule

// File: rtl/z80_xyflag_unit.sv
module z80_xyflag_unit
  import z80xf_pkg::*;
#(
  parameter bit IS_CMOS       = 1'b0,
  parameter bit CLONE_KEEP_CF = 1'b0,
  parameter bit DIFF_OR       = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [CLS_W-1:0]  op_class,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] flags_in,
  input  logic [DATA_W-1:0] alu_res,
  input  logic [MP_W-1:0]   memptr,
  input  logic [DATA_W-1:0] b_pre,
  output logic              yf_out,
  output logic              xf_out,
  output logic              cf_out,
  output logic [DATA_W-1:0] port_byte
);
  localparam int NLANE = 2;
  logic             hist_q;
  logic [NLANE-1:0] lane_out;

  z80xf_history u_hist (
    .clk(clk), .rst_n(rst_n), .step_en(step_en),
    .op_class(op_class), .hist_q(hist_q)
  );

  for (genvar gi = 0; gi < NLANE; gi++) begin : g_lane
    localparam int FP = (gi == 1) ? YPOS : XPOS;
    localparam int MP = (gi == 1) ? MP_YP : MP_XP;
    z80xf_lane #(.DIFF_OR(DIFF_OR)) u_lane (
      .op_class(op_class), .hist_q(hist_q),
      .acc_bit(acc[FP]), .flag_bit(flags_in[FP]),
      .res_bit(alu_res[FP]), .mp_bit(memptr[MP]),
      .out_bit(lane_out[gi])
    );
  end

  assign yf_out = lane_out[1];
  assign xf_out = lane_out[0];

  z80xf_quirks #(.IS_CMOS(IS_CMOS), .CLONE_KEEP_CF(CLONE_KEEP_CF)) u_quirk (
    .op_class(op_class), .b_pre(b_pre), .cf_in(flags_in[CPOS]),
    .cf_out(cf_out), .port_byte(port_byte)
  );

  // R1: ALU result bits reach the flags
  a_r1_alu_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == CLS_ALU) |-> (yf_out == alu_res[YPOS] && xf_out == alu_res[XPOS]));
  // R2: after a flag write, SCF/CCF copy the accumulator
  a_r2_copy_acc: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_class == CLS_SCF || op_class == CLS_CCF) && hist_q)
      |-> (yf_out == acc[YPOS] && xf_out == acc[XPOS]));
  // R3: agreeing bits survive the merge
  a_r3_agree: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_class == CLS_SCF || op_class == CLS_CCF) && !hist_q
      && flags_in[YPOS] == acc[YPOS]) |-> (yf_out == acc[YPOS]));
  // R5: BIT (HL) takes MEMPTR bits
  a_r5_memptr: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == CLS_BITM) |-> (yf_out == memptr[MP_YP] && xf_out == memptr[MP_XP]));
  // R6: last-pass OUTI carry per variant
  a_r6_outi_last: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == CLS_OUTI && b_pre == 8'd1)
      |-> (cf_out == (CLONE_KEEP_CF ? flags_in[CPOS] : 1'b0)));
  // R7: otherwise carry passes through
  a_r7_cf_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_class == CLS_OUTI && b_pre == 8'd1) |-> (cf_out == flags_in[CPOS]));
endmodule

// File: tb/z80_xyflag_unit_test.sv
module z80_xyflag_unit_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_en = 1'b0;
  logic [3:0] op_class = 4'h7;
  logic [7:0] acc = '0, flags_in = '0, alu_res = '0, b_pre = '0;
  logic [15:0] memptr = '0;
  logic       yf_a, xf_a, cf_a, yf_b, xf_b, cf_b;
  logic [7:0] pb_a, pb_b;
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  // NMOS, standard carry, OR on disagreement
  z80_xyflag_unit #(.IS_CMOS(1'b0), .CLONE_KEEP_CF(1'b0), .DIFF_OR(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .op_class(op_class),
    .acc(acc), .flags_in(flags_in), .alu_res(alu_res), .memptr(memptr),
    .b_pre(b_pre), .yf_out(yf_a), .xf_out(xf_a), .cf_out(cf_a), .port_byte(pb_a));
  // CMOS, clone carry, AND on disagreement
  z80_xyflag_unit #(.IS_CMOS(1'b1), .CLONE_KEEP_CF(1'b1), .DIFF_OR(1'b0)) uut_alt (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .op_class(op_class),
    .acc(acc), .flags_in(flags_in), .alu_res(alu_res), .memptr(memptr),
    .b_pre(b_pre), .yf_out(yf_b), .xf_out(xf_b), .cf_out(cf_b), .port_byte(pb_b));

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // present one instruction at a falling edge; outputs are valid 1 unit later
  task automatic issue(input logic [3:0] c, input logic [7:0] a, input logic [7:0] f,
                       input logic [7:0] r, input logic [15:0] m, input logic [7:0] b,
                       input logic en);
    @(negedge clk);
    op_class = c; acc = a; flags_in = f; alu_res = r; memptr = m; b_pre = b; step_en = en;
    #1;
  endtask

  task automatic t_reset_state;
    // history is 0 after reset: SCF merges, bits 5 and 3 disagree (f=00, a=28)
    issue(4'h1, 8'h28, 8'h00, 8'h00, 16'h0, 8'h0, 1'b1);
    chk("R9 reset hist, R4 OR y/x", {6'b0, yf_a, xf_a}, 8'h03);
    chk("R9 reset hist, R4 AND y/x", {6'b0, yf_b, xf_b}, 8'h00);
  endtask

  task automatic t_alu;
    issue(4'h0, 8'h00, 8'h00, 8'h28, 16'h0, 8'h0, 1'b1);   // OR 28h
    chk("R1 OR 28h", {6'b0, yf_a, xf_a}, 8'h03);
    issue(4'h0, 8'hFF, 8'hFF, 8'hD7, 16'h0, 8'h0, 1'b1);   // AND 0D7h on FFh
    chk("R1 AND D7h", {6'b0, yf_b, xf_b}, 8'h00);
  endtask

  task automatic t_copy_after_write;
    issue(4'h0, 8'h00, 8'h00, 8'h00, 16'h0, 8'h0, 1'b1);
    issue(4'h1, 8'h20, 8'h08, 8'h00, 16'h0, 8'h0, 1'b1);
    chk("R2 SCF copy", {6'b0, yf_a, xf_a}, 8'h02);
    chk("R2 SCF copy alt", {6'b0, yf_b, xf_b}, 8'h02);
    issue(4'h2, 8'h08, 8'h20, 8'h00, 16'h0, 8'h0, 1'b1);   // after SCF (a flag write)
    chk("R2 CCF copy", {6'b0, yf_a, xf_a}, 8'h01);
  endtask

  task automatic t_merge_after_pop;
    issue(4'h6, 8'h00, 8'h00, 8'h00, 16'h0, 8'h0, 1'b1);
    issue(4'h1, 8'h28, 8'h28, 8'h00, 16'h0, 8'h0, 1'b1);
    chk("R3 both set", {6'b0, yf_b, xf_b}, 8'h03);
    issue(4'h6, 8'h00, 8'h00, 8'h00, 16'h0, 8'h0, 1'b1);
    issue(4'h2, 8'h00, 8'hD7, 8'h00, 16'h0, 8'h0, 1'b1);
    chk("R3 both clear", {6'b0, yf_a, xf_a}, 8'h00);
    issue(4'h6, 8'h00, 8'h00, 8'h00, 16'h0, 8'h0, 1'b1);
    issue(4'h1, 8'h20, 8'h08, 8'h00, 16'h0, 8'h0, 1'b1);
    chk("R4 differ OR", {6'b0, yf_a, xf_a}, 8'h03);
    chk("R4 differ AND", {6'b0, yf_b, xf_b}, 8'h00);
  endtask

  task automatic t_bit_memptr;
    issue(4'h3, 8'hFF, 8'h00, 8'hFF, 16'h2800, 8'h0, 1'b1);
    chk("R5 memptr 2800", {6'b0, yf_a, xf_a}, 8'h03);
    issue(4'h3, 8'h00, 8'hFF, 8'h00, 16'hD7FF, 8'h0, 1'b1);
    chk("R5 memptr D7FF", {6'b0, yf_b, xf_b}, 8'h00);
  endtask

  task automatic t_outi_detect;
    // HL=FFFFh, B=1, carry set, then OUTI
    issue(4'h1, 8'h00, 8'h00, 8'h00, 16'h0, 8'h0, 1'b1);
    issue(4'h4, 8'h00, 8'h01, 8'h00, 16'hFFFF, 8'h01, 1'b1);
    chk("R6 OUTI B=1 standard", {7'b0, cf_a}, 8'h00);
    chk("R6 OUTI B=1 clone", {7'b0, cf_b}, 8'h01);
    issue(4'h4, 8'h00, 8'h01, 8'h00, 16'h0, 8'h02, 1'b1);
    chk("R7 OUTI B=2 keeps 1", {6'b0, cf_a, cf_b}, 8'h03);
    issue(4'h4, 8'h00, 8'h00, 8'h00, 16'h0, 8'h00, 1'b1);
    chk("R7 OUTI B=0 keeps 0", {6'b0, cf_a, cf_b}, 8'h00);
    issue(4'h0, 8'h00, 8'h01, 8'h00, 16'h0, 8'h01, 1'b1);
    chk("R7 ALU carry passes", {6'b0, cf_a, cf_b}, 8'h03);
    // history after OUTI: SCF copies
    issue(4'h4, 8'h00, 8'h00, 8'h00, 16'h0, 8'h05, 1'b1);
    issue(4'h1, 8'h20, 8'h08, 8'h00, 16'h0, 8'h0, 1'b1);
    chk("R9 OUTI sets hist", {6'b0, yf_a, xf_a}, 8'h02);
  endtask

  task automatic t_port_zero;
    logic [7:0] rb_a, rb_b;
    issue(4'h5, 8'h00, 8'h28, 8'h00, 16'h0, 8'h0, 1'b1);
    rb_a = pb_a; rb_b = pb_b;                         // read-back of the written port
    chk("R8 NMOS port byte", rb_a, 8'h00);
    chk("R8 CMOS port byte", rb_b, 8'hFF);
    chk("R7 OUT-zero y/x pass", {6'b0, yf_a, xf_a}, 8'h03);
    issue(4'h1, 8'h20, 8'h08, 8'h00, 16'h0, 8'h0, 1'b1);
    chk("R9 OUT-zero clears hist", {6'b0, yf_a, xf_a}, 8'h03);
    chk("R8 other class byte", pb_b, 8'h00);
  endtask

  task automatic t_hold;
    issue(4'h6, 8'h00, 8'h00, 8'h00, 16'h0, 8'h0, 1'b1);
    issue(4'h0, 8'h00, 8'h00, 8'h00, 16'h0, 8'h0, 1'b0);  // not completing
    issue(4'h1, 8'h20, 8'h08, 8'h00, 16'h0, 8'h0, 1'b1);
    chk("R9 hold without step_en", {6'b0, yf_a, xf_a}, 8'h03);
  endtask

  task automatic t_unused_codes;
    issue(4'h0, 8'h00, 8'h00, 8'h00, 16'h0, 8'h0, 1'b1);
    issue(4'hB, 8'hFF, 8'h09, 8'hFF, 16'hFFFF, 8'h01, 1'b1);
    chk("R10 code B y/x/c pass", {5'b0, yf_a, xf_a, cf_a}, 8'h03);
    issue(4'h1, 8'h20, 8'h08, 8'h00, 16'h0, 8'h0, 1'b1);
    chk("R10 code B clears hist", {6'b0, yf_a, xf_a}, 8'h03);
    issue(4'h0, 8'h00, 8'h00, 8'h00, 16'h0, 8'h0, 1'b1);
    issue(4'h7, 8'h00, 8'h20, 8'h00, 16'h0, 8'h0, 1'b1);
    chk("R10 no-flag y/x pass", {6'b0, yf_b, xf_b}, 8'h02);
  endtask

  initial begin
    #(CLK_P * 20000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset port byte", pb_a, 8'h00);
    rst_n = 1'b1;
    t_reset_state();
    t_alu();
    t_copy_after_write();
    t_merge_after_pop();
    t_bit_memptr();
    t_outi_detect();
    t_port_zero();
    t_hold();
    t_unused_codes();
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule